// File: doc/BRIEF.md
# Shared-Line Interrupt Router

This block steers eight level-sensitive device interrupt lines (PIRQ A through H) and one power-management interrupt level (SCI) onto two sets of outputs. The first set is a bank of 16 legacy PIC request lines. The second is a bank of 24 I/O APIC global system interrupt (GSI) lines. On the PIC side each PIRQ has a programmable route byte. The byte either names one of the 16 PIC lines or turns that PIRQ off, so several PIRQs can end up wired-OR onto one PIC line. On the APIC side the mapping is fixed and never shared: PIRQ n always drives GSI 16+n.

A 3-bit select code places the SCI on one of five interrupt numbers. Its level is ORed into the GSI of that number, and also into the PIC line of that number when the number is below 16. A small configuration write port loads the eight route bytes and the SCI select. The PIRQ and SCI levels are registered once on entry. Every output is then formed combinationally from those stored levels and the stored configuration, so each output follows its inputs or a configuration write after one clock edge.

Top module: `pirq_irq_router`

## Requirements
- R1: A route byte uses bits 3:0 as the PIC line number and bit 7 as a disable flag. When bit 7 is 0, an asserted PIRQ drives `pic_irq_o` at that line number after one rising edge.
- R2: A PIRQ whose route byte has bit 7 set drives no PIC line, whatever its line field holds.
- R3: Each PIC line is the OR of every enabled, asserted PIRQ routed to it. Two PIRQs sharing a line keep it high while either one is high.
- R4: PIRQ n (A=0 … H=7) drives `gsi_o[16+n]` regardless of its route byte.
- R5: SCI select code 0 targets interrupt 9, 1 targets 10, 2 targets 11, 4 targets 20 and 5 targets 21. Codes 3, 6 and 7 are reserved and route the SCI to no output.
- R6: An asserted SCI drives the GSI of its target. It also drives the PIC line of the same number only when the target is below 16. GSIs 0–15 carry nothing else. Holding the SCI at an unchanged level leaves the outputs unchanged.
- R7: When the SCI and a PIRQ land on the same PIC line or the same GSI, that output is their OR.
- R8: While `rst_n` is low, every output is 0. After reset every route byte is 0x80 (disabled), the SCI select is 0 (interrupt 9), and the stored levels are cleared.
- R9: Configuration addresses 0–3 hold the route bytes of PIRQ A–D and 4–7 those of PIRQ E–H. Address 8 holds the SCI select in data bits 2:0. Writes to addresses 9–15 change nothing.
- R10: A configuration write takes effect on the outputs in the cycle after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration register address |
| cfg_wdata | input | 8 | Configuration write data |
| pirq_in | input | 8 | PIRQ levels, bit 0 = A … bit 7 = H |
| sci_in | input | 1 | SCI level |
| pic_irq_o | output | 16 | Legacy PIC request lines |
| gsi_o | output | 24 | I/O APIC GSI lines |

## Verification
Because the outputs hold no state of their own, a wrong route byte or SCI select shows at the ports on the very next cycle. It appears as a bit set on the wrong PIC line or GSI, or as a bit that never rises. A stuck or aliased configuration address shows up as a route change that the bench did not write. It becomes visible as soon as the affected PIRQ is asserted. A mistake in the stored SCI level or the reset values shows the moment reset is released with all inputs driven high.

// File: rtl/pirq_router_pkg.sv
package pirq_router_pkg;
  localparam int ROUTE_W     = 8;
  localparam int LINE_W      = 4;
  localparam int OFF_BIT     = 7;
  localparam int SEL_W       = 3;
  localparam int TGT_W       = 5;
  localparam logic [ROUTE_W-1:0] ROUTE_RST = 8'h80;
  localparam logic [SEL_W-1:0]   SEL_RST   = 3'd0;

  typedef struct packed {
    logic             hit;
    logic [TGT_W-1:0] num;
  } sci_tgt_t;

  // Maps the SCI select code to its interrupt number; reserved codes miss.
  function automatic sci_tgt_t sci_decode(input logic [SEL_W-1:0] sel);
    sci_tgt_t t;
    t.hit = 1'b1;
    case (sel)
      3'd0:    t.num = 5'd9;
      3'd1:    t.num = 5'd10;
      3'd2:    t.num = 5'd11;
      3'd4:    t.num = 5'd20;
      3'd5:    t.num = 5'd21;
      default: begin t.hit = 1'b0; t.num = '0; end
    endcase
    return t;
  endfunction

  // True when an enabled route byte names the given PIC line.
  function automatic logic route_hits(input logic [ROUTE_W-1:0] rb,
                                      input logic [LINE_W-1:0] line);
    return !rb[OFF_BIT] && (rb[LINE_W-1:0] == line);
  endfunction
endpackage

// File: rtl/pirq_cfg_regs.sv
module pirq_cfg_regs
  import pirq_router_pkg::*;
#(
  parameter int NUM_PIRQ = 8,
  parameter int ADDR_W   = 4
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             cfg_we,
  input  logic [ADDR_W-1:0]                cfg_addr,
  input  logic [ROUTE_W-1:0]               cfg_wdata,
  output logic [NUM_PIRQ-1:0][ROUTE_W-1:0] route_q,
  output logic [SEL_W-1:0]                 sel_q
);
  localparam logic [ADDR_W-1:0] SEL_ADDR = ADDR_W'(NUM_PIRQ);

  for (genvar g = 0; g < NUM_PIRQ; g++) begin : g_route
    logic wr_hit;
    assign wr_hit = cfg_we && (cfg_addr == ADDR_W'(g));
    always_ff @(posedge clk) begin
      if (!rst_n)      route_q[g] <= ROUTE_RST;
      else if (wr_hit) route_q[g] <= cfg_wdata;
    end
  end

  logic sel_wr;
  assign sel_wr = cfg_we && (cfg_addr == SEL_ADDR);

  always_ff @(posedge clk) begin
    if (!rst_n)      sel_q <= SEL_RST;
    else if (sel_wr) sel_q <= cfg_wdata[SEL_W-1:0];
  end
endmodule

// File: rtl/pirq_pic_merge.sv
module pirq_pic_merge
  import pirq_router_pkg::*;
#(
  parameter int NUM_PIRQ = 8,
  parameter int NUM_PIC  = 16
) (
  input  logic [NUM_PIRQ-1:0][ROUTE_W-1:0] route_q,
  input  logic [NUM_PIRQ-1:0]              pirq_q,
  input  logic                             sci_q,
  input  sci_tgt_t                         sci_tgt,
  output logic [NUM_PIC-1:0]               pic_o
);
  for (genvar k = 0; k < NUM_PIC; k++) begin : g_line
    logic from_pirq;
    logic from_sci;
    always_comb begin
      from_pirq = 1'b0;
      for (int n = 0; n < NUM_PIRQ; n++) begin
        from_pirq = from_pirq | (pirq_q[n] & route_hits(route_q[n], LINE_W'(k)));
      end
    end
    assign from_sci = sci_q && sci_tgt.hit && (sci_tgt.num == TGT_W'(k));
    assign pic_o[k] = from_pirq | from_sci;
  end
endmodule

// File: rtl/pirq_apic_merge.sv
module pirq_apic_merge
  import pirq_router_pkg::*;
#(
  parameter int NUM_PIRQ = 8,
  parameter int NUM_PIC  = 16,
  parameter int NUM_GSI  = 24
) (
  input  logic [NUM_PIRQ-1:0] pirq_q,
  input  logic                sci_q,
  input  sci_tgt_t            sci_tgt,
  output logic [NUM_GSI-1:0]  gsi_o
);
  for (genvar g = 0; g < NUM_GSI; g++) begin : g_gsi
    logic from_sci;
    assign from_sci = sci_q && sci_tgt.hit && (sci_tgt.num == TGT_W'(g));
    if (g >= NUM_PIC && g < NUM_PIC + NUM_PIRQ) begin : g_dedicated
      assign gsi_o[g] = pirq_q[g-NUM_PIC] | from_sci;
    end else begin : g_sci_only
      assign gsi_o[g] = from_sci;
    end
  end
endmodule

// File: rtl/pirq_irq_router.sv
module pirq_irq_router
  import pirq_router_pkg::*;
#(
  parameter int NUM_PIRQ = 8,
  parameter int NUM_PIC  = 16,
  parameter int NUM_GSI  = 24,
  parameter int ADDR_W   = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [ADDR_W-1:0]   cfg_addr,
  input  logic [ROUTE_W-1:0]  cfg_wdata,
  input  logic [NUM_PIRQ-1:0] pirq_in,
  input  logic                sci_in,
  output logic [NUM_PIC-1:0]  pic_irq_o,
  output logic [NUM_GSI-1:0]  gsi_o
);
  logic [NUM_PIRQ-1:0][ROUTE_W-1:0] route_q;
  logic [SEL_W-1:0]                 sel_q;
  logic [NUM_PIRQ-1:0]              pirq_q;
  logic                             sci_q;
  sci_tgt_t                         sci_tgt;

  // Stored input levels; an unchanged SCI level rewrites the same value.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pirq_q <= '0;
      sci_q  <= 1'b0;
    end else begin
      pirq_q <= pirq_in;
      sci_q  <= sci_in;
    end
  end

  pirq_cfg_regs #(.NUM_PIRQ(NUM_PIRQ), .ADDR_W(ADDR_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .route_q(route_q), .sel_q(sel_q)
  );

  assign sci_tgt = sci_decode(sel_q);

  pirq_pic_merge #(.NUM_PIRQ(NUM_PIRQ), .NUM_PIC(NUM_PIC)) u_pic (
    .route_q(route_q), .pirq_q(pirq_q), .sci_q(sci_q),
    .sci_tgt(sci_tgt), .pic_o(pic_irq_o)
  );

  pirq_apic_merge #(.NUM_PIRQ(NUM_PIRQ), .NUM_PIC(NUM_PIC), .NUM_GSI(NUM_GSI)) u_apic (
    .pirq_q(pirq_q), .sci_q(sci_q), .sci_tgt(sci_tgt), .gsi_o(gsi_o)
  );
endmodule

// File: rtl/pirq_irq_router_chk.sv
module pirq_irq_router_chk
  import pirq_router_pkg::*;
#(
  parameter int NUM_PIRQ = 8,
  parameter int NUM_PIC  = 16,
  parameter int NUM_GSI  = 24
) (
  input logic                             clk,
  input logic                             rst_n,
  input logic [NUM_PIRQ-1:0][ROUTE_W-1:0] route_q,
  input logic [NUM_PIRQ-1:0]              pirq_q,
  input logic                             sci_q,
  input sci_tgt_t                         sci_tgt,
  input logic [NUM_PIC-1:0]               pic_irq_o,
  input logic [NUM_GSI-1:0]               gsi_o
);
  for (genvar n = 0; n < NUM_PIRQ; n++) begin : g_pirq
    p_gsi_dedicated_r4: assert property (@(posedge clk) disable iff (!rst_n)
      pirq_q[n] |-> gsi_o[NUM_PIC+n]);
    p_pic_routed_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (pirq_q[n] && !route_q[n][OFF_BIT]) |-> pic_irq_o[route_q[n][LINE_W-1:0]]);
  end

  p_sci_gsi_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sci_q && sci_tgt.hit) |-> gsi_o[sci_tgt.num]);

  p_sci_pic_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sci_q && sci_tgt.hit && sci_tgt.num < TGT_W'(NUM_PIC)) |-> pic_irq_o[sci_tgt.num[LINE_W-1:0]]);

  p_sci_reserved_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!sci_tgt.hit && pirq_q == '0) |-> (pic_irq_o == '0 && gsi_o == '0));

  p_reset_quiet_r8: assert property (@(posedge clk)
    !rst_n |=> (pic_irq_o == '0 && gsi_o == '0));
endmodule

bind pirq_irq_router pirq_irq_router_chk #(
  .NUM_PIRQ(NUM_PIRQ), .NUM_PIC(NUM_PIC), .NUM_GSI(NUM_GSI)
) u_chk (
  .clk(clk), .rst_n(rst_n), .route_q(route_q), .pirq_q(pirq_q),
  .sci_q(sci_q), .sci_tgt(sci_tgt), .pic_irq_o(pic_irq_o), .gsi_o(gsi_o)
);

// File: tb/tb_pirq_irq_router.sv
module tb_pirq_irq_router;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [7:0]  cfg_wdata = '0;
  logic [7:0]  pirq_in = '0;
  logic        sci_in = 1'b0;
  logic [15:0] pic_irq_o;
  logic [23:0] gsi_o;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  pirq_irq_router dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .pirq_in(pirq_in), .sci_in(sci_in),
    .pic_irq_o(pic_irq_o), .gsi_o(gsi_o)
  );

  // {pirq, sci, expected pic, expected gsi}; routes A,B->5 C->9 D off E->14 F->0 G off H->15, SCI on 9
  localparam logic [48:0] VECS [10] = '{
    {8'h01, 1'b0, 16'h0020, 24'h010000},
    {8'h03, 1'b0, 16'h0020, 24'h030000},
    {8'h08, 1'b0, 16'h0000, 24'h080000},
    {8'h04, 1'b1, 16'h0200, 24'h040200},
    {8'h00, 1'b1, 16'h0200, 24'h000200},
    {8'h10, 1'b0, 16'h4000, 24'h100000},
    {8'h20, 1'b0, 16'h0001, 24'h200000},
    {8'h40, 1'b0, 16'h0000, 24'h400000},
    {8'h80, 1'b0, 16'h8000, 24'h800000},
    {8'hFF, 1'b0, 16'hC221, 24'hFF0000}
  };

  function automatic int sci_line(input int code);
    if (code == 0) return 9;
    if (code == 1) return 10;
    if (code == 2) return 11;
    if (code == 4) return 20;
    if (code == 5) return 21;
    return -1;
  endfunction

  task automatic check(input string req, input logic [15:0] ep, input logic [23:0] eg);
    checks++;
    if (pic_irq_o !== ep || gsi_o !== eg) begin
      errors++;
      $display("FAIL %s pic=%h gsi=%h expected pic=%h gsi=%h", req, pic_irq_o, gsi_o, ep, eg);
    end
  endtask

  task automatic apply(input logic [7:0] p, input logic s);
    @(negedge clk);
    pirq_in = p;
    sci_in  = s;
    @(negedge clk);
  endtask

  task automatic cfg_write(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    pirq_in = 8'hFF; sci_in = 1'b1;
    repeat (3) @(negedge clk);
    check("R8 outputs low in reset", 16'h0000, 24'h000000);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8 defaults routes off SCI on 9", 16'h0200, 24'hFF0200);

    apply(8'h00, 1'b0);
    cfg_write(4'd0, 8'h05); cfg_write(4'd1, 8'h05);
    cfg_write(4'd2, 8'h09); cfg_write(4'd3, 8'h83);
    cfg_write(4'd4, 8'h0E); cfg_write(4'd5, 8'h00);
    cfg_write(4'd6, 8'h8F); cfg_write(4'd7, 8'h0F);
    cfg_write(4'd8, 8'h00);

    for (int i = 0; i < 10; i++) begin
      apply(VECS[i][48:41], VECS[i][40]);
      check($sformatf("R1 R2 R3 R4 R7 table vector %0d", i), VECS[i][39:24], VECS[i][23:0]);
    end

    apply(8'h00, 1'b1);
    check("R6 SCI level held unchanged", 16'h0200, 24'h000200);

    for (int c = 0; c < 8; c++) begin
      int ln;
      cfg_write(4'd8, 8'(c));
      ln = sci_line(c);
      check($sformatf("R5 R6 SCI select code %0d", c),
            (ln >= 0 && ln < 16) ? 16'(1 << ln) : 16'h0000,
            (ln >= 0) ? 24'(1 << ln) : 24'h000000);
    end

    cfg_write(4'd8, 8'h04);
    apply(8'h10, 1'b1);
    check("R7 SCI and PIRQ E share GSI 20", 16'h4000, 24'h100000);
    apply(8'h10, 1'b0);
    check("R7 GSI 20 held by PIRQ E alone", 16'h4000, 24'h100000);
    apply(8'h00, 1'b1);
    check("R7 GSI 20 held by SCI alone", 16'h0000, 24'h100000);
    apply(8'h00, 1'b0);

    apply(8'h11, 1'b0);
    check("R9 before unmapped writes", 16'h4020, 24'h110000);
    cfg_write(4'd12, 8'h80);
    cfg_write(4'd9, 8'h87);
    cfg_write(4'd15, 8'h00);
    check("R9 addresses 9-15 ignored", 16'h4020, 24'h110000);

    cfg_write(4'd0, 8'h07);
    check("R10 reroute A visible next cycle", 16'h4080, 24'h110000);
    cfg_write(4'd0, 8'h87);
    check("R2 R10 disable A next cycle", 16'h4000, 24'h110000);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule